// File: doc/BRIEF.md
# Pipeline Stage Skid-Buffer Controller

This block controls one in-order pipeline stage that sits between an upstream token source and a downstream consumer. Each cycle it receives a group of up to `IN_W` tokens. Every token carries a sequence number, a squash mark and a count of source operands. The block forwards up to `OUT_W` live tokens per cycle. Tokens that arrive already squashed are dropped and do not take an output lane. A forwarded token that has no source operands is flagged as ready to issue.

Three downstream sources can stall the stage, and each has its own set and clear pulse. While any of them is stalled, incoming tokens are parked in a skid buffer. The block tells upstream to stop by sending a one-cycle `up_block` pulse. When the stalls clear, the block first drains the parked tokens in an Unblocking phase, and only then sends `up_unblock` so that upstream can resume. A flush request discards everything the block holds and moves it to a Squashing state. A separate "flush still in progress" input holds it there.

The input has no ready signal: the stage accepts every group it is offered. Back-pressure is the block/unblock pulse pair, and upstream may keep sending for up to `UP_DELAY` cycles after a block pulse. The skid buffer holds `UP_DELAY*IN_W + OUT_W` tokens to absorb that traffic. The output has no ready signal either: downstream stalls through the stall pulses. Valid input lanes are packed from lane 0, and `in_count` must not exceed `IN_W`.

Top module: `stg_skid_ctl`

## Requirements
- R1: After reset the state is Idle (code 0), the skid level is 0, no output lane is valid and neither upstream pulse is high.
- R2: Each stall source has a flag that its set pulse raises and its clear pulse drops, with clear winning when both arrive together. The stage is stalled in a cycle when any flag, updated by that cycle's pulses, is set.
- R3: In Idle, Running (1) or Squashing (4), with no flush and no stall, the block forwards up to `OUT_W` unsquashed input tokens in the same cycle. They are packed from output lane 0 in arrival order, and squashed tokens take no lane. Idle and Running keep their state.
- R4: `out_issue_rdy[k]` is high exactly when lane k is valid and its token has a source-operand count of zero.
- R5: If input tokens remain after all `OUT_W` lanes are filled (squashed ones included), the remainder goes into the skid buffer in order. `up_block` pulses in that cycle and the state becomes Blocked (2).
- R6: With a stall active and no flush, nothing is forwarded and all incoming tokens are appended to the skid buffer. The state becomes Blocked, and `up_block` pulses only if the state was not already Blocked.
- R7: In Blocked or Unblocking (3) with no stall and no flush, tokens are forwarded from the head of the skid buffer under the R3 rules, and incoming tokens are appended behind. If the buffer is empty after that cycle, `up_unblock` pulses and the state becomes Running; otherwise the state becomes Unblocking.
- R8: A flush request has top priority. It discards the skid buffer and the incoming tokens, forwards nothing, and moves the state to Squashing with a skid level of 0.
- R9: A flush in Blocked, or in Unblocking with no stall active, pulses `up_unblock`. A flush in Unblocking with a stall active sends neither pulse, because the block is cancelled. A flush in any other state sends no pulse.
- R10: The flush-in-progress input, without a flush request, enters or stays in Squashing, discards held and incoming tokens, and forwards nothing.
- R11: From Squashing, a cycle without flush, flush-in-progress or stall moves to Running and forwards that cycle's input.
- R12: The skid buffer holds `UP_DELAY*IN_W + OUT_W` tokens. An append beyond that raises `overflow_err` in that cycle, drops the excess and leaves the level at capacity.
- R13: `up_block` and `up_unblock` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_count | input | $clog2(IN_W+1) | Number of valid input lanes, packed from lane 0 |
| in_seq | input | IN_W*SEQ_W | Sequence number per input lane |
| in_squashed | input | IN_W | Squash mark per input lane |
| in_nsrc | input | IN_W*SRC_W | Source-operand count per input lane |
| stall_on | input | NSTALL | Stall set pulse per downstream source |
| stall_off | input | NSTALL | Stall clear pulse per downstream source |
| flush_req | input | 1 | Flush: discard everything, enter Squashing |
| flush_busy | input | 1 | Flush still in progress: stay in Squashing |
| out_valid | output | OUT_W | Output lane valid, packed from lane 0 |
| out_seq | output | OUT_W*SEQ_W | Sequence number per output lane |
| out_issue_rdy | output | OUT_W | Forwarded token has no source operands |
| up_block | output | 1 | One-cycle pulse asking upstream to stop |
| up_unblock | output | 1 | One-cycle pulse allowing upstream to resume |
| state_o | output | 3 | Current state code |
| skid_level | output | $clog2(DEPTH+1) | Tokens held in the skid buffer |
| overflow_err | output | 1 | An append exceeded skid capacity this cycle |

## Verification
The sharpest overlap comes from a flush request arriving in the same cycle as a stall set pulse while the stage is Unblocking with tokens parked. On its own, the stall would raise `up_block`, and on its own, the flush would raise `up_unblock`. The bench provokes this cycle directly and expects neither pulse, followed by Squashing with an empty buffer. It contrasts this with a flush in Blocked, which must pulse `up_unblock`, and a flush in Running, which must be silent. Stall set and clear pulses on one source in the same cycle are also driven together, and the bench expects the tokens to be forwarded with no block pulse.

// File: rtl/stg_pkg.sv
`timescale 1ns/1ps
package stg_pkg;
  localparam int SEQ_W = 8;
  localparam int SRC_W = 2;

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic             sq;
    logic [SRC_W-1:0] nsrc;
  } tok_t;

  localparam int TOK_W = $bits(tok_t);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_BLK   = 3'd2,
    ST_UNBLK = 3'd3,
    ST_SQ    = 3'd4
  } st_e;
endpackage

// File: rtl/stg_stall_flags.sv
`timescale 1ns/1ps
module stg_stall_flags #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic            stalled_o
);
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] flag_n;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign flag_n[g] = (flag_q[g] | set_i[g]) & ~clr_i[g];

    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= flag_n[g];
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[g] && !clr_i[g]) |=> flag_q[g]);   // R2
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[g] |=> !flag_q[g]);                 // R2
  end

  assign stalled_o = |flag_n;
endmodule

// File: rtl/stg_tok_picker.sv
`timescale 1ns/1ps
module stg_tok_picker
  import stg_pkg::*;
#(
  parameter int N     = 4,
  parameter int OUT_W = 2,
  localparam int AW   = $clog2(N + 1),
  localparam int SW   = $clog2(OUT_W + 1)
) (
  input  tok_t [N-1:0]     toks_i,
  input  logic [AW-1:0]    avail_i,
  output tok_t [OUT_W-1:0] toks_o,
  output logic [OUT_W-1:0] vld_o,
  output logic [AW-1:0]    used_o
);
  logic [SW-1:0] slot;
  logic          full;

  always_comb begin
    toks_o = '0;
    vld_o  = '0;
    used_o = avail_i;
    slot   = '0;
    full   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!full && (AW'(i) < avail_i) && !toks_i[i].sq) begin
        for (int j = 0; j < OUT_W; j++) begin
          if (SW'(j) == slot) begin
            toks_o[j] = toks_i[i];
            vld_o[j]  = 1'b1;
          end
        end
        slot = slot + SW'(1);
        if (slot == SW'(OUT_W)) begin
          full   = 1'b1;
          used_o = AW'(i + 1);
        end
      end
    end
  end
endmodule

// File: rtl/stg_skid.sv
`timescale 1ns/1ps
module stg_skid
  import stg_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int IN_W  = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(IN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [CW-1:0]    pop_i,
  input  logic [PW-1:0]    push_i,
  input  tok_t [IN_W-1:0]  push_toks_i,
  output tok_t [DEPTH-1:0] mem_o,
  output logic [CW-1:0]    cnt_o,
  output logic             ovf_o
);
  tok_t [DEPTH-1:0] mem_q, mem_n;
  logic [CW-1:0]    cnt_q, cnt_n, base;

  always_comb begin
    mem_n = mem_q >> (int'(pop_i) * TOK_W);
    base  = cnt_q - pop_i;
    cnt_n = base;
    ovf_o = 1'b0;
    for (int j = 0; j < IN_W; j++) begin
      if (PW'(j) < push_i) begin
        if ((int'(base) + j) < DEPTH) begin
          for (int k = 0; k < DEPTH; k++) begin
            if (k == int'(base) + j) mem_n[k] = push_toks_i[j];
          end
          cnt_n = cnt_n + CW'(1);
        end else begin
          ovf_o = 1'b1;
        end
      end
    end
    if (clr_i) begin
      mem_n = '0;
      cnt_n = '0;
      ovf_o = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_n;
      cnt_q <= cnt_n;
    end
  end

  assign mem_o = mem_q;
  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));                      // R12
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));                  // R8
  AST_POP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i <= cnt_q);                           // R7
endmodule

// File: rtl/stg_skid_ctl.sv
`timescale 1ns/1ps
module stg_skid_ctl
  import stg_pkg::*;
#(
  parameter int IN_W     = 4,
  parameter int OUT_W    = 2,
  parameter int UP_DELAY = 2,
  parameter int NSTALL   = 3,
  localparam int DEPTH   = UP_DELAY * IN_W + OUT_W,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int PW      = $clog2(IN_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PW-1:0]           in_count,
  input  logic [IN_W*SEQ_W-1:0]   in_seq,
  input  logic [IN_W-1:0]         in_squashed,
  input  logic [IN_W*SRC_W-1:0]   in_nsrc,
  input  logic [NSTALL-1:0]       stall_on,
  input  logic [NSTALL-1:0]       stall_off,
  input  logic                    flush_req,
  input  logic                    flush_busy,
  output logic [OUT_W-1:0]        out_valid,
  output logic [OUT_W*SEQ_W-1:0]  out_seq,
  output logic [OUT_W-1:0]        out_issue_rdy,
  output logic                    up_block,
  output logic                    up_unblock,
  output logic [2:0]              state_o,
  output logic [CW-1:0]           skid_level,
  output logic                    overflow_err
);
  st_e              st_q, st_n;
  logic             stalled;
  tok_t [IN_W-1:0]  in_toks, push_toks;
  tok_t [DEPTH-1:0] sk_mem;
  tok_t [OUT_W-1:0] in_otok, sk_otok;
  logic [OUT_W-1:0] in_ovld, sk_ovld;
  logic [PW-1:0]    in_used, sk_push, push_off;
  logic [CW-1:0]    sk_used, sk_pop;
  logic             sk_clr, use_sk, use_in;

  for (genvar l = 0; l < IN_W; l++) begin : g_in
    assign in_toks[l].seq  = in_seq[l*SEQ_W +: SEQ_W];
    assign in_toks[l].sq   = in_squashed[l];
    assign in_toks[l].nsrc = in_nsrc[l*SRC_W +: SRC_W];
  end

  stg_stall_flags #(.NSRC(NSTALL)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(stall_on), .clr_i(stall_off),
    .stalled_o(stalled)
  );

  stg_tok_picker #(.N(IN_W), .OUT_W(OUT_W)) u_pick_in (
    .toks_i(in_toks), .avail_i(in_count),
    .toks_o(in_otok), .vld_o(in_ovld), .used_o(in_used)
  );

  stg_tok_picker #(.N(DEPTH), .OUT_W(OUT_W)) u_pick_sk (
    .toks_i(sk_mem), .avail_i(skid_level),
    .toks_o(sk_otok), .vld_o(sk_ovld), .used_o(sk_used)
  );

  assign push_toks = in_toks >> (int'(push_off) * TOK_W);

  stg_skid #(.DEPTH(DEPTH), .IN_W(IN_W)) u_skid (
    .clk(clk), .rst_n(rst_n), .clr_i(sk_clr), .pop_i(sk_pop),
    .push_i(sk_push), .push_toks_i(push_toks),
    .mem_o(sk_mem), .cnt_o(skid_level), .ovf_o(overflow_err)
  );

  // Priority: flush, flush in progress, stall, drain, forward.
  always_comb begin
    st_n       = st_q;
    up_block   = 1'b0;
    up_unblock = 1'b0;
    sk_clr     = 1'b0;
    sk_pop     = '0;
    sk_push    = '0;
    push_off   = '0;
    use_sk     = 1'b0;
    use_in     = 1'b0;
    if (flush_req) begin
      sk_clr = 1'b1;
      st_n   = ST_SQ;
      if (st_q == ST_BLK) up_unblock = 1'b1;
      else if (st_q == ST_UNBLK && !stalled) up_unblock = 1'b1;
    end else if (flush_busy) begin
      sk_clr = 1'b1;
      st_n   = ST_SQ;
    end else if (stalled) begin
      st_n     = ST_BLK;
      up_block = (st_q != ST_BLK);
      sk_push  = in_count;
    end else if (st_q == ST_BLK || st_q == ST_UNBLK) begin
      use_sk  = 1'b1;
      sk_pop  = sk_used;
      sk_push = in_count;
      if (skid_level == sk_used && in_count == '0) begin
        up_unblock = 1'b1;
        st_n       = ST_RUN;
      end else begin
        st_n = ST_UNBLK;
      end
    end else begin
      use_in = 1'b1;
      if (st_q == ST_SQ) st_n = ST_RUN;
      if (in_used != in_count) begin
        push_off = in_used;
        sk_push  = in_count - in_used;
        up_block = 1'b1;
        st_n     = ST_BLK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  assign state_o = st_q;

  for (genvar k = 0; k < OUT_W; k++) begin : g_out
    tok_t lane_t;
    assign lane_t           = use_sk ? sk_otok[k] : in_otok[k];
    assign out_valid[k]     = use_sk ? sk_ovld[k] : (use_in & in_ovld[k]);
    assign out_seq[k*SEQ_W +: SEQ_W] = lane_t.seq;
    assign out_issue_rdy[k] = out_valid[k] && (lane_t.nsrc == '0);

    AST_NO_SQ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[k] |-> !lane_t.sq);            // R3
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_block && up_unblock));                // R13
  AST_OUT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid + OUT_W'(1)) & out_valid) == '0);  // R3
  AST_RDY_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_issue_rdy & ~out_valid) == '0);       // R4
  AST_SKID_HELD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (skid_level != '0) |-> (st_q == ST_BLK || st_q == ST_UNBLK));  // R7
  AST_BLOCK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    up_block |=> (st_q == ST_BLK));            // R6
  AST_UNBLOCK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_unblock && !flush_req) |=> (st_q == ST_RUN));  // R7
  AST_FLUSH_SQ: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (st_q == ST_SQ && skid_level == '0)); // R8
endmodule

// File: tb/stg_skid_ctl_tb_top.sv
`timescale 1ns/1ps
module stg_skid_ctl_tb_top;
  localparam int IN_W = 4;
  localparam int OUT_W = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  in_count = '0;
  logic [31:0] in_seq = '0;
  logic [3:0]  in_squashed = '0;
  logic [7:0]  in_nsrc = '0;
  logic [2:0]  stall_on = '0;
  logic [2:0]  stall_off = '0;
  logic        flush_req = 1'b0;
  logic        flush_busy = 1'b0;
  logic [1:0]  out_valid;
  logic [15:0] out_seq;
  logic [1:0]  out_issue_rdy;
  logic        up_block, up_unblock;
  logic [2:0]  state_o;
  logic [3:0]  skid_level;
  logic        overflow_err;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stg_skid_ctl #(.IN_W(IN_W), .OUT_W(OUT_W), .UP_DELAY(2), .NSTALL(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_count(in_count), .in_seq(in_seq),
    .in_squashed(in_squashed), .in_nsrc(in_nsrc), .stall_on(stall_on),
    .stall_off(stall_off), .flush_req(flush_req), .flush_busy(flush_busy),
    .out_valid(out_valid), .out_seq(out_seq), .out_issue_rdy(out_issue_rdy),
    .up_block(up_block), .up_unblock(up_unblock), .state_o(state_o),
    .skid_level(skid_level), .overflow_err(overflow_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int n, input int s0, input logic [3:0] sqm,
                       input logic [3:0] zm, input logic [2:0] on,
                       input logic [2:0] off, input logic fl, input logic fb);
    @(negedge clk);
    in_count = 3'(n);
    for (int i = 0; i < IN_W; i++) begin
      in_seq[i*8 +: 8]  = 8'(s0 + i);
      in_squashed[i]    = sqm[i];
      in_nsrc[i*2 +: 2] = zm[i] ? 2'd0 : 2'd1;
    end
    stall_on = on; stall_off = off; flush_req = fl; flush_busy = fb;
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 4'b0, 4'b0, 3'b0, 3'b0, 1'b0, 1'b0);
  endtask

  task automatic chk_out(input string tag, input int n, input int s0, input int s1);
    chk({tag, " out count"}, $countones(out_valid), n);
    if (n > 0) chk({tag, " lane0 seq"}, int'(out_seq[7:0]), s0);
    if (n > 1) chk({tag, " lane1 seq"}, int'(out_seq[15:8]), s1);
  endtask

  task automatic chk_pulse(input string tag, input int b, input int u);
    chk({tag, " up_block"}, int'(up_block), b);
    chk({tag, " up_unblock"}, int'(up_unblock), u);
  endtask

  task automatic chk_st(input string tag, input int st, input int lvl);
    chk({tag, " state"}, int'(state_o), st);
    chk({tag, " skid level"}, int'(skid_level), lvl);
  endtask

  task automatic t_reset();
    idle();
    chk_st("R1 reset", 0, 0);
    chk_out("R1 reset", 0, 0, 0);
    chk_pulse("R1 reset", 0, 0);
  endtask

  task automatic t_forward();
    drive(2, 10, 4'b0000, 4'b0001, 3'b0, 3'b0, 1'b0, 1'b0);
    chk_out("R3 plain", 2, 10, 11);
    chk("R4 issue ready", int'(out_issue_rdy), 1);
    chk_pulse("R3 plain", 0, 0);
    drive(3, 20, 4'b0010, 4'b0000, 3'b0, 3'b0, 1'b0, 1'b0);
    chk_st("R3 idle kept", 0, 0);
    chk_out("R3 squashed dropped", 2, 20, 22);
    chk("R4 none ready", int'(out_issue_rdy), 0);
    chk_pulse("R3 no block", 0, 0);
  endtask

  task automatic t_width();
    drive(4, 30, 4'b0, 4'b0, 3'b0, 3'b0, 1'b0, 1'b0);
    chk_out("R5 excess", 2, 30, 31);
    chk_pulse("R5 excess", 1, 0);
    chk("R13 no unblock with block", int'(up_unblock), 0);
    idle();
    chk_st("R5 parked", 2, 2);
    chk_out("R7 drain", 2, 32, 33);
    chk_pulse("R7 drain done", 0, 1);
    drive(3, 40, 4'b0100, 4'b0, 3'b0, 3'b0, 1'b0, 1'b0);
    chk_st("R7 running", 1, 0);
    chk_out("R5 trailing squashed", 2, 40, 41);
    chk_pulse("R5 trailing squashed", 1, 0);
    idle();
    chk_st("R5 trailing parked", 2, 1);
    chk_out("R7 drop squashed head", 0, 0, 0);
    chk_pulse("R7 drop squashed head", 0, 1);
    idle();
    chk_st("R7 back to running", 1, 0);
  endtask

  task automatic t_stall();
    drive(3, 50, 4'b0, 4'b0, 3'b010, 3'b0, 1'b0, 1'b0);
    chk_out("R6 stalled", 0, 0, 0);
    chk_pulse("R6 first block", 1, 0);
    drive(2, 53, 4'b0, 4'b0, 3'b0, 3'b0, 1'b0, 1'b0);
    chk_st("R6 blocked", 2, 3);
    chk_out("R6 held", 0, 0, 0);
    chk_pulse("R6 no repeat block", 0, 0);
    drive(0, 0, 4'b0, 4'b0, 3'b0, 3'b010, 1'b0, 1'b0);
    chk_st("R6 appended", 2, 5);
    chk_out("R7 unblock first", 2, 50, 51);
    chk_pulse("R7 still draining", 0, 0);
    drive(1, 55, 4'b0, 4'b0, 3'b0, 3'b0, 1'b0, 1'b0);
    chk_st("R7 unblocking", 3, 3);
    chk_out("R7 skid before input", 2, 52, 53);
    chk_pulse("R7 still draining 2", 0, 0);
    idle();
    chk_st("R7 appended behind", 3, 2);
    chk_out("R7 last drain", 2, 54, 55);
    chk_pulse("R7 unblock pulse", 0, 1);
    drive(2, 60, 4'b0, 4'b0, 3'b100, 3'b100, 1'b0, 1'b0);
    chk_st("R7 running", 1, 0);
    chk_out("R2 clear wins", 2, 60, 61);
    chk_pulse("R2 clear wins", 0, 0);
    drive(0, 0, 4'b0, 4'b0, 3'b101, 3'b0, 1'b0, 1'b0);
    chk_pulse("R2 two sources", 1, 0);
    drive(0, 0, 4'b0, 4'b0, 3'b0, 3'b001, 1'b0, 1'b0);
    chk_st("R2 blocked", 2, 0);
    chk_pulse("R2 one flag left", 0, 0);
    drive(0, 0, 4'b0, 4'b0, 3'b0, 3'b100, 1'b0, 1'b0);
    chk_pulse("R2 all clear", 0, 1);
    idle();
    chk_st("R2 running", 1, 0);
  endtask

  task automatic t_flush();
    drive(2, 70, 4'b0, 4'b0, 3'b001, 3'b0, 1'b0, 1'b0);
    chk_pulse("R6 block", 1, 0);
    drive(2, 72, 4'b0, 4'b0, 3'b0, 3'b0, 1'b1, 1'b0);
    chk_st("R6 parked", 2, 2);
    chk_out("R8 flush", 0, 0, 0);
    chk_pulse("R9 flush in blocked", 0, 1);
    drive(0, 0, 4'b0, 4'b0, 3'b0, 3'b001, 1'b0, 1'b0);
    chk_st("R8 squashing", 4, 0);
    chk_pulse("R11 leave squash", 0, 0);
    drive(4, 80, 4'b0, 4'b0, 3'b0, 3'b0, 1'b0, 1'b0);
    chk_st("R11 running", 1, 0);
    chk_out("R5 excess again", 2, 80, 81);
    drive(4, 84, 4'b0, 4'b0, 3'b0, 3'b0, 1'b0, 1'b0);
    chk_st("R5 blocked", 2, 2);
    chk_out("R7 drain", 2, 82, 83);
    chk_pulse("R7 not empty", 0, 0);
    drive(0, 0, 4'b0, 4'b0, 3'b010, 3'b0, 1'b1, 1'b0);
    chk_st("R7 unblocking", 3, 4);
    chk_pulse("R9 cancel", 0, 0);
    chk_out("R8 nothing out", 0, 0, 0);
    drive(0, 0, 4'b0, 4'b0, 3'b0, 3'b010, 1'b0, 1'b0);
    chk_st("R8 emptied", 4, 0);
    drive(0, 0, 4'b0, 4'b0, 3'b0, 3'b0, 1'b1, 1'b0);
    chk_st("R11 running", 1, 0);
    chk_pulse("R9 flush in running", 0, 0);
  endtask

  task automatic t_busy();
    drive(2, 90, 4'b0, 4'b0, 3'b0, 3'b0, 1'b0, 1'b1);
    chk_st("R8 squashing", 4, 0);
    chk_out("R10 busy drops", 0, 0, 0);
    drive(2, 92, 4'b0, 4'b0010, 3'b0, 3'b0, 1'b0, 1'b0);
    chk_st("R10 still squashing", 4, 0);
    chk_out("R11 forward", 2, 92, 93);
    chk("R4 lane1 ready", int'(out_issue_rdy), 2);
    idle();
    chk_st("R11 running", 1, 0);
  endtask

  task automatic t_overflow();
    drive(4, 100, 4'b0, 4'b0, 3'b001, 3'b0, 1'b0, 1'b0);
    chk("R12 no overflow 1", int'(overflow_err), 0);
    drive(4, 104, 4'b0, 4'b0, 3'b0, 3'b0, 1'b0, 1'b0);
    chk("R12 no overflow 2", int'(overflow_err), 0);
    drive(4, 108, 4'b0, 4'b0, 3'b0, 3'b0, 1'b0, 1'b0);
    chk("R12 level 8", int'(skid_level), 8);
    chk("R12 overflow", int'(overflow_err), 1);
    drive(0, 0, 4'b0, 4'b0, 3'b0, 3'b001, 1'b1, 1'b0);
    chk_st("R12 saturated", 2, 10);
    idle();
    chk_st("R8 cleaned", 4, 0);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_forward();
    t_width();
    t_stall();
    t_flush();
    t_busy();
    t_overflow();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule